// File: doc/BRIEF.md
# Receive Stream Source Selector with Requantizer

This block sits at the head of the receive capture path and decides which of three streams feeds it. The three are the filter-bank channelizer output, the raw converter samples on a bypass path, and a counter test pattern. Every stream moves four complex samples per clock and has a single valid flag. The channelizer produces 25-bit signed values with 23 fraction bits. Before that stream reaches the selector, each real and imaginary component is reduced to the common 16-bit signed format with 15 fraction bits. The reduction rounds half up and then saturates. The bypass and counter streams pass through bit for bit.

A two-bit mode input picks the source. The block does not take a new mode while a beat of the current source is arriving. It loads the mode only on a clock edge where the selected source's valid is low, and the new source governs beats from the following clock onward. The output valid and the output data are both registered. Every mode therefore has exactly one cycle of latency. The output data keeps its last value between beats.

Top module: `rx_src_select`

## Requirements
- R1: modeSel encodes the source as 0 = channelizer, 1 = bypass, 2 = counter. Code 3 is reserved: no output beat is produced while it is active, whatever the input valids do.
- R2: In bypass mode each accepted beat appears on outData unchanged. Lane k occupies bits [32k+31:32k], with the real part in the low 16 bits and the imaginary part in the high 16 bits.
- R3: In counter mode each accepted beat appears on outData unchanged, with the same lane layout as R2.
- R4: In channelizer mode, lane k of chanData holds the real part at bits [50k+24:50k] and the imaginary part at bits [50k+49:50k+25]. Each is a signed value with 23 fraction bits. The output is floor((x + 128) / 256), placed in the R2 layout. For example, 384 gives 2, -384 gives -1, 127 gives 0 and 128 gives 1.
- R5: When the rounded channelizer value exceeds 32767 it is output as 32767, and when it is below -32768 it is output as -32768. Each real and imaginary component of each lane is limited on its own.
- R6: outValid is high in exactly the cycle after the selected source's valid was high, and it is low otherwise. The valids and data of the sources that are not selected have no effect on the outputs.
- R7: The mode is loaded from modeSel only on a clock edge where the currently selected source's valid is low. A beat of the new source is accepted from the next clock. While the current source's valid stays high, beats keep coming from the current source.
- R8: outData changes only on an accepted beat and keeps its previous value otherwise.
- R9: While rstN is low, outValid is 0, outData is all zeros and the active source is the channelizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Requested source (0 channelizer, 1 bypass, 2 counter, 3 reserved) |
| chanValid | input | 1 | Channelizer beat valid |
| chanData | input | 200 | Four complex channelizer samples, 25-bit components |
| bypValid | input | 1 | Bypass beat valid |
| bypData | input | 128 | Four complex raw samples, 16-bit components |
| cntValid | input | 1 | Counter pattern beat valid |
| cntData | input | 128 | Four complex counter samples, 16-bit components |
| outValid | output | 1 | Output beat valid |
| outData | output | 128 | Four complex output samples, 16-bit components |

## Verification
The only state between an accepted input beat and its result is one register stage. The bench applies each beat after a falling edge. It then lets exactly one rising edge pass and compares outValid and outData at the next falling edge. One more falling edge later, it checks that outValid has dropped again.

A mode change is expected to need one edge with the selected valid low before a beat of the new source can be accepted. The bench therefore idles the valids for one clock after every modeSel change. The R7 test is the exception: there it holds the old source's valid high on purpose and expects the old source's data to keep coming. The expected rounded and saturated values come from a floor-division formula written in the bench, not from shifts.

// File: rtl/rx_src_pkg.sv
package rx_src_pkg;

  typedef enum logic [1:0] {
    SRC_CHAN = 2'd0,
    SRC_BYP  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_NONE = 2'd3
  } srcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     take;   // selected source presents a beat this cycle
    srcMode_e sel;    // source that owns the beat
  } dpCtrl_t;

endpackage

// File: rtl/rx_src_requant.sv
// One component: signed IN_W/IN_FRAC -> signed OUT_W/OUT_FRAC,
// round half up, then clamp to the output range.
module rx_src_requant #(
  parameter int IN_W     = 25,
  parameter int IN_FRAC  = 23,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 15
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int SHIFT = IN_FRAC - OUT_FRAC;
  localparam int SUM_W = IN_W + 1;

  generate
    if (SHIFT > 0) begin : g_round
      localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (SHIFT - 1);
      localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 1);
      localparam logic signed [SUM_W-1:0] MINV = -(SUM_W'(64'sd1 <<< (OUT_W - 1)));
      logic signed [SUM_W-1:0] biased;
      logic signed [SUM_W-1:0] rounded;
      always_comb begin
        biased  = {din[IN_W-1], din} + HALF;
        rounded = biased >>> SHIFT;
        if (rounded > MAXV)      dout = {1'b0, {(OUT_W-1){1'b1}}};
        else if (rounded < MINV) dout = {1'b1, {(OUT_W-1){1'b0}}};
        else                     dout = rounded[OUT_W-1:0];
      end
    end else begin : g_direct
      assign dout = din[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/rx_src_ctrl.sv
module rx_src_ctrl
  import rx_src_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       chanValid,
  input  logic       bypValid,
  input  logic       cntValid,
  output dpCtrl_t    dpCtrl,
  output srcMode_e   curMode,
  output logic       outValid
);
  logic selValid;

  always_comb begin
    unique case (curMode)
      SRC_CHAN: selValid = chanValid;
      SRC_BYP:  selValid = bypValid;
      SRC_CNT:  selValid = cntValid;
      default:  selValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode  <= SRC_CHAN;
      outValid <= 1'b0;
    end else begin
      outValid <= selValid;
      // mode only moves in a gap of the current source
      if (!selValid) curMode <= srcMode_e'(modeSel);
    end
  end

  always_comb begin
    dpCtrl.take = selValid;
    dpCtrl.sel  = curMode;
  end

endmodule

// File: rtl/rx_src_dp.sv
module rx_src_dp
  import rx_src_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int IN_W     = 25,
  parameter int IN_FRAC  = 23,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 15,
  localparam int CH_W    = LANES * 2 * IN_W,
  localparam int BUS_W   = LANES * 2 * OUT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [CH_W-1:0]  chanData,
  input  logic [BUS_W-1:0] bypData,
  input  logic [BUS_W-1:0] cntData,
  output logic [BUS_W-1:0] outData
);
  localparam int NCOMP = LANES * 2;

  logic [BUS_W-1:0] chanQ;
  logic [BUS_W-1:0] muxed;

  // component c: lane c/2, c even = real, odd = imaginary
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic signed [OUT_W-1:0] q;
    rx_src_requant #(
      .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
    ) requantI (
      .din (chanData[c*IN_W +: IN_W]),
      .dout(q)
    );
    assign chanQ[c*OUT_W +: OUT_W] = q;
  end

  always_comb begin
    unique case (dpCtrl.sel)
      SRC_CHAN: muxed = chanQ;
      SRC_BYP:  muxed = bypData;
      SRC_CNT:  muxed = cntData;
      default:  muxed = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outData <= '0;
    else if (dpCtrl.take) outData <= muxed;
  end

endmodule

// File: rtl/rx_src_select.sv
module rx_src_select
  import rx_src_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int IN_W     = 25,
  parameter int IN_FRAC  = 23,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 15,
  localparam int CH_W    = LANES * 2 * IN_W,
  localparam int BUS_W   = LANES * 2 * OUT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             chanValid,
  input  logic [CH_W-1:0]  chanData,
  input  logic             bypValid,
  input  logic [BUS_W-1:0] bypData,
  input  logic             cntValid,
  input  logic [BUS_W-1:0] cntData,
  output logic             outValid,
  output logic [BUS_W-1:0] outData
);
  dpCtrl_t  dpCtrl;
  srcMode_e curMode;

  rx_src_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .chanValid(chanValid),
    .bypValid (bypValid),
    .cntValid (cntValid),
    .dpCtrl   (dpCtrl),
    .curMode  (curMode),
    .outValid (outValid)
  );

  rx_src_dp #(
    .LANES(LANES), .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
  ) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .chanData(chanData),
    .bypData (bypData),
    .cntData (cntData),
    .outData (outData)
  );

endmodule

// File: rtl/rx_src_select_chk.sv
module rx_src_select_chk #(
  parameter int BUS_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       curMode,
  input logic             chanValid,
  input logic             bypValid,
  input logic             cntValid,
  input logic [BUS_W-1:0] bypData,
  input logic [BUS_W-1:0] cntData,
  input logic             outValid,
  input logic [BUS_W-1:0] outData
);
  logic selV;
  always_comb begin
    case (curMode)
      2'd0:    selV = chanValid;
      2'd1:    selV = bypValid;
      2'd2:    selV = cntValid;
      default: selV = 1'b0;
    endcase
  end

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd3) |=> !outValid);  // R1
  AST_BYP_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd1 && bypValid) |=> (outValid && outData == $past(bypData)));  // R2
  AST_CNT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd2 && cntValid) |=> (outValid && outData == $past(cntData)));  // R3
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    !selV |=> !outValid);  // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    selV |=> $stable(curMode));  // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !selV |=> $stable(outData));  // R8

endmodule

bind rx_src_select rx_src_select_chk #(.BUS_W(BUS_W)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .curMode  (curMode),
  .chanValid(chanValid),
  .bypValid (bypValid),
  .cntValid (cntValid),
  .bypData  (bypData),
  .cntData  (cntData),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/rx_src_select_tb_top.sv
`timescale 1ns/1ps
module rx_src_select_tb_top;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   modeSel;
  logic         chanValid, bypValid, cntValid;
  logic [199:0] chanData;
  logic [127:0] bypData, cntData;
  logic         outValid;
  logic [127:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  logic [127:0] lastOut = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rx_src_select dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .chanValid(chanValid), .chanData(chanData),
    .bypValid(bypValid), .bypData(bypData),
    .cntValid(cntValid), .cntData(cntData),
    .outValid(outValid), .outData(outData)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [24:0] re;
    logic [24:0] im;
    logic [31:0] raw;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 25'sd384,      -25'sd384,      32'h0},  // R4 half-up both signs
    '{2'd0, 25'sd127,      25'sd128,       32'h0},  // R4 threshold
    '{2'd0, -25'sd129,     -25'sd128,      32'h0},  // R4 negative side
    '{2'd0, 25'sd16777215, -25'sd16777216, 32'h0},  // R5 full-scale rails
    '{2'd0, 25'sd8388480,  -25'sd8388737,  32'h0},  // R5 just past the rails
    '{2'd0, 25'sd8388479,  -25'sd8388608,  32'h0},  // R5 just inside
    '{2'd1, 25'sd0,        25'sd0,         32'h1234abcd},  // R2
    '{2'd2, 25'sd0,        25'sd0,         32'h00050007},  // R3
    '{2'd1, 25'sd0,        25'sd0,         32'h8000ffff}   // R2
  };

  // floor((x+128)/256) with clamp, written with integer division
  function automatic logic [15:0] expQ(input int x);
    int q, r;
    q = x + 128;
    if (q >= 0) r = q / 256;
    else        r = -((-q + 255) / 256);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  function automatic int sx25(input logic [24:0] v);
    return int'(signed'(v));
  endfunction

  task automatic check(input string req, input logic ev, input logic [127:0] ed);
    nChecks++;
    if (outValid !== ev || outData !== ed) begin
      nFails++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               req, outValid, outData, ev, ed);
    end
  endtask

  task automatic idle();
    chanValid = 1'b0; bypValid = 1'b0; cntValid = 1'b0;
  endtask

  // called right after a falling edge; leaves one edge with valids low
  task automatic setMode(input logic [1:0] m);
    modeSel = m;
    idle();
    @(negedge clk);
  endtask

  task automatic beat(input logic cv, input logic bv, input logic nv);
    chanValid = cv; bypValid = bv; cntValid = nv;
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] exp;
    rstN = 1'b0; modeSel = 2'd0; idle();
    chanData = '0; bypData = '0; cntData = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      setMode(VECS[i].mode);
      exp = '0;
      for (int k = 0; k < 4; k++) begin
        logic [24:0] r, m;
        r = (k < 2) ? VECS[i].re : VECS[i].im;
        m = (k < 2) ? VECS[i].im : VECS[i].re;
        chanData[k*50 +: 25]      = r;
        chanData[k*50 + 25 +: 25] = m;
        bypData[k*32 +: 32] = VECS[i].raw + 32'(k);
        cntData[k*32 +: 32] = ~VECS[i].raw - 32'(k);
        if (VECS[i].mode == 2'd0) begin
          exp[k*32 +: 16]      = expQ(sx25(r));
          exp[k*32 + 16 +: 16] = expQ(sx25(m));
        end else if (VECS[i].mode == 2'd1) exp[k*32 +: 32] = bypData[k*32 +: 32];
        else                               exp[k*32 +: 32] = cntData[k*32 +: 32];
      end
      beat(1'b1, 1'b1, 1'b1);  // only the selected valid may matter
      check(VECS[i].mode == 2'd0 ? "R4/R5 channelizer" :
            VECS[i].mode == 2'd1 ? "R2 bypass" : "R3 counter", 1'b1, exp);
      lastOut = exp;
    end

    // R6: valid drops one cycle after the beat
    @(negedge clk);
    check("R6 valid falls", 1'b0, lastOut);

    // R5: lanes limited independently, mixed rails in one beat
    setMode(2'd0);
    chanData[0 +: 25] = 25'sd16777215;  chanData[25 +: 25]  = 25'sd256;
    chanData[50 +: 25] = -25'sd16777216; chanData[75 +: 25] = -25'sd256;
    chanData[100 +: 25] = 25'sd0;        chanData[125 +: 25] = 25'sd8388736;
    chanData[150 +: 25] = -25'sd8388864; chanData[175 +: 25] = 25'sd383;
    exp = {16'd1, 16'h8000, 16'h7fff, 16'd0, 16'hffff, 16'h8000, 16'd1, 16'h7fff};
    beat(1'b1, 1'b0, 1'b0);
    check("R5 per-lane clamp", 1'b1, exp);
    lastOut = exp;

    // R6: non-selected sources ignored
    setMode(2'd1);
    bypData = {4{32'hdeadbeef}}; cntData = {4{32'h0badf00d}};
    beat(1'b1, 1'b0, 1'b1);
    check("R6 other valids ignored", 1'b0, lastOut);

    // R1: reserved code gives no beat, R8 data holds
    setMode(2'd3);
    beat(1'b1, 1'b1, 1'b1);
    check("R1 reserved silent", 1'b0, lastOut);
    @(negedge clk);
    check("R8 data holds", 1'b0, lastOut);

    // R7: mode change waits for a gap in the current source
    setMode(2'd1);
    bypData = {4{32'h11112222}}; bypValid = 1'b1; modeSel = 2'd2;
    @(negedge clk);
    check("R7 first bypass beat", 1'b1, {4{32'h11112222}});
    bypData = {4{32'h33334444}}; cntData = {4{32'h55556666}}; cntValid = 1'b1;
    @(negedge clk);
    check("R7 bypass still owns stream", 1'b1, {4{32'h33334444}});
    bypValid = 1'b0; cntData = {4{32'h77778888}};
    @(negedge clk);  // gap edge: mode loads, counter beat not yet taken
    check("R7 gap edge", 1'b0, {4{32'h33334444}});
    cntData = {4{32'h9999aaaa}};
    @(negedge clk);
    check("R7 counter after gap", 1'b1, {4{32'h9999aaaa}});
    idle();
    @(negedge clk);
    check("R6 valid low after last beat", 1'b0, {4{32'h9999aaaa}});

    // R9: reset in mid-stream clears outputs
    cntValid = 1'b1;
    @(negedge clk);
    rstN = 1'b0; idle();
    @(negedge clk);
    check("R9 reset clears", 1'b0, '0);
    rstN = 1'b1; modeSel = 2'd0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule